// File: doc/BRIEF.md
# Per-Thread Interrupt Priority Presenter

This block keeps the interrupt state of a single processor thread. It has a pending buffer with one bit for each priority level, a processor priority threshold (`cppr`), a clamped pending priority (`pipr`) and a notification status byte (`nsr`). It drives one level-sensitive exception line toward the CPU. A lower priority number is more privileged. Priority `p` is held in pending bit `NPRIO-1-p`, so the most significant bit holds priority 0.

Three kinds of event reach the block. An interrupt router marks a priority as pending. Software writes a new threshold. The processor issues an accept to take the interrupt. The pending priority and the exception condition are worked out again after every cycle in which any of these occurs. The block takes every event on every cycle and applies no back-pressure. Each event input is a one-cycle strobe. An accept is answered one cycle later by a single-cycle response strobe that carries a 16-bit snapshot of the status.

Top module: `ipp_presenter`

## Requirements
- R1: After reset the threshold is 0, the pending buffer is empty, `nsr` is 0, `pipr_o` is 0 and `irq_o` is low. An accept issued at that point returns 16'h0000.
- R2: A router strobe with priority `p` sets pending bit `NPRIO-1-p` in the cycle after it. The bit stays set until an accept takes that priority.
- R3: The raw priority is the index of the leftmost set pending bit counted from the MSB, or 8'hFF when the buffer is empty. `pipr_o` is the smaller of the raw priority and the threshold, so it never reads 8'hFF.
- R4: The exception-outstanding flag (`nsr` bit 7) and `irq_o` are high exactly when the raw priority is numerically below the threshold. Both are updated in the cycle after the event that changed the buffer or the threshold.
- R5: A threshold write of a value above `NPRIO-1` (7 by default) is dropped, and the threshold keeps its previous value. A write of exactly 7 is taken.
- R6: An accept strobe is answered in the next cycle by `acc_rsp_valid` high for one cycle. `acc_rsp_data` then carries {`nsr`, threshold} as they stood in the accept cycle, with `nsr` in bits 15:8.
- R7: An accept while the exception flag is set makes three changes. The threshold becomes the accepted priority. That priority's pending bit is cleared. `nsr` is cleared and `irq_o` falls, unless a same-cycle router strobe raises a more privileged priority.
- R8: An accept while the exception flag is clear changes neither the threshold nor the pending buffer.
- R9: A router strobe and a threshold write in the same cycle are both applied before `pipr_o` and the exception condition are evaluated.
- R10: A threshold write that leaves the raw priority no longer below the threshold drops `irq_o` and the exception flag.
- R11: When an exception-taking accept and a legal threshold write land in the same cycle, the written value wins. The accepted pending bit is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_valid | input | 1 | Router strobe: mark a priority pending |
| set_prio | input | PW (3) | Priority named by the router strobe |
| cppr_wr | input | 1 | Threshold write strobe |
| cppr_wdata | input | 8 | Value for the threshold write |
| acc_valid | input | 1 | Accept strobe from the processor |
| acc_rsp_valid | output | 1 | One-cycle strobe answering an accept |
| acc_rsp_data | output | 16 | {nsr, threshold} sampled in the accept cycle |
| ipb_o | output | NPRIO (8) | Pending buffer, bit NPRIO-1 is priority 0 |
| pipr_o | output | 8 | Clamped pending priority |
| irq_o | output | 1 | Level exception line to the CPU |

## Verification
The checker tests some relations on every cycle. `pipr_o` never exceeds the threshold, and `irq_o` implies that `pipr_o` is below it. The threshold never leaves the legal range. A router strobe always leaves its bit set. Each accept response matches the status held in the previous cycle. A quiet accept leaves the buffer and the threshold unchanged. Only the bench's scenarios can show the sequence effects. These are the exact threshold taken on an accept, the write that wins over a same-cycle accept, the evaluation of a same-cycle set and write, and the line dropping when the threshold is lowered.

// File: rtl/ipp_pkg.sv
package ipp_pkg;
  localparam int          REG_W      = 8;
  localparam int          EO_BIT     = 7;
  localparam logic [7:0]  RAW_EMPTY  = 8'hFF;

  typedef logic [REG_W-1:0] byte_t;

  function automatic byte_t min_byte(input byte_t a, input byte_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/ipp_prio_enc.sv
module ipp_prio_enc
  import ipp_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input  logic [NPRIO-1:0] vec,
  output byte_t            prio
);
  logic [NPRIO-1:0] by_prio;

  // reorder so index equals priority number
  for (genvar g = 0; g < NPRIO; g++) begin : g_rev
    assign by_prio[g] = vec[NPRIO-1-g];
  end

  always_comb begin
    prio = RAW_EMPTY;
    for (int p = NPRIO-1; p >= 0; p--) begin
      if (by_prio[p]) prio = byte_t'(p);
    end
  end
endmodule

// File: rtl/ipp_pend_buf.sv
module ipp_pend_buf #(
  parameter int NPRIO = 8,
  localparam int PW = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_fire,
  input  logic [PW-1:0]    set_prio,
  input  logic             clr_fire,
  input  logic [PW-1:0]    clr_prio,
  output logic [NPRIO-1:0] ipb_q,
  output logic [NPRIO-1:0] ipb_next
);
  logic [NPRIO-1:0] set_mask, clr_mask;

  always_comb begin
    for (int i = 0; i < NPRIO; i++) begin
      set_mask[i] = set_fire && (int'(set_prio) == NPRIO-1-i);
      clr_mask[i] = clr_fire && (int'(clr_prio) == NPRIO-1-i);
    end
  end

  // clear of the accepted level first, new marks on top
  assign ipb_next = (ipb_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ipb_q <= '0;
    else        ipb_q <= ipb_next;
  end
endmodule

// File: rtl/ipp_cppr_ctl.sv
module ipp_cppr_ctl
  import ipp_pkg::*;
#(
  parameter int NPRIO = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_fire,
  input  byte_t wr_val,
  input  logic  acc_take,
  input  byte_t acc_prio,
  output byte_t cppr_q,
  output byte_t cppr_next
);
  localparam byte_t MAX_PRIO = byte_t'(NPRIO-1);

  logic wr_legal;
  assign wr_legal = wr_fire && (wr_val <= MAX_PRIO);

  always_comb begin
    if (wr_legal)      cppr_next = wr_val;
    else if (acc_take) cppr_next = acc_prio;
    else               cppr_next = cppr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cppr_q <= '0;
    else        cppr_q <= cppr_next;
  end
endmodule

// File: rtl/ipp_presenter.sv
module ipp_presenter
  import ipp_pkg::*;
#(
  parameter int NPRIO = 8,
  localparam int PW = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [PW-1:0]    set_prio,
  input  logic             cppr_wr,
  input  logic [7:0]       cppr_wdata,
  input  logic             acc_valid,
  output logic             acc_rsp_valid,
  output logic [15:0]      acc_rsp_data,
  output logic [NPRIO-1:0] ipb_o,
  output logic [7:0]       pipr_o,
  output logic             irq_o
);
  byte_t            cppr_q, cppr_next;
  byte_t            nsr_q, nsr_next;
  byte_t            pipr_q, pipr_next;
  byte_t            cur_raw, nxt_raw;
  logic [NPRIO-1:0] ipb_q, ipb_next;
  logic             acc_take, exc_next;

  assign acc_take = acc_valid && nsr_q[EO_BIT];

  ipp_prio_enc #(.NPRIO(NPRIO)) u_enc_cur (.vec(ipb_q),    .prio(cur_raw));
  ipp_prio_enc #(.NPRIO(NPRIO)) u_enc_nxt (.vec(ipb_next), .prio(nxt_raw));

  ipp_pend_buf #(.NPRIO(NPRIO)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_fire (set_valid),
    .set_prio (set_prio),
    .clr_fire (acc_take),
    .clr_prio (cur_raw[PW-1:0]),
    .ipb_q    (ipb_q),
    .ipb_next (ipb_next)
  );

  ipp_cppr_ctl #(.NPRIO(NPRIO)) u_cppr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (cppr_wr),
    .wr_val    (cppr_wdata),
    .acc_take  (acc_take),
    .acc_prio  (cur_raw),
    .cppr_q    (cppr_q),
    .cppr_next (cppr_next)
  );

  // evaluate on post-event state
  assign exc_next  = nxt_raw < cppr_next;
  assign pipr_next = min_byte(nxt_raw, cppr_next);
  assign nsr_next  = exc_next ? byte_t'(1 << EO_BIT) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsr_q         <= '0;
      pipr_q        <= '0;
      acc_rsp_valid <= 1'b0;
      acc_rsp_data  <= '0;
    end else begin
      nsr_q         <= nsr_next;
      pipr_q        <= pipr_next;
      acc_rsp_valid <= acc_valid;
      if (acc_valid) acc_rsp_data <= {nsr_q, cppr_q};
    end
  end

  assign ipb_o  = ipb_q;
  assign pipr_o = pipr_q;
  assign irq_o  = nsr_q[EO_BIT];
endmodule

// File: rtl/ipp_presenter_chk.sv
module ipp_presenter_chk #(
  parameter int NPRIO = 8,
  localparam int PW = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             set_valid,
  input logic [PW-1:0]    set_prio,
  input logic             cppr_wr,
  input logic [7:0]       cppr_wdata,
  input logic             acc_valid,
  input logic             acc_rsp_valid,
  input logic [15:0]      acc_rsp_data,
  input logic [NPRIO-1:0] ipb_o,
  input logic [7:0]       pipr_o,
  input logic             irq_o,
  input logic [7:0]       cppr_q,
  input logic [7:0]       nsr_q
);
  logic [NPRIO-1:0] set_mask;
  always_comb begin
    for (int i = 0; i < NPRIO; i++) set_mask[i] = (int'(set_prio) == NPRIO-1-i);
  end

  // R3
  pipr_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipr_o <= cppr_q);

  // R4
  irq_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pipr_o < cppr_q));

  // R5
  cppr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cppr_q <= 8'(NPRIO-1));

  // R5
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_wr && cppr_wdata > 8'(NPRIO-1) && !acc_valid) |=> $stable(cppr_q));

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> ((ipb_o & $past(set_mask)) == $past(set_mask)));

  // R6
  rsp_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (acc_rsp_valid && acc_rsp_data == {$past(nsr_q), $past(cppr_q)}));

  // R6
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !acc_rsp_valid);

  // R8
  quiet_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !irq_o && !set_valid && !cppr_wr) |=> ($stable(ipb_o) && $stable(cppr_q)));
endmodule

bind ipp_presenter ipp_presenter_chk #(.NPRIO(NPRIO)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .set_valid     (set_valid),
  .set_prio      (set_prio),
  .cppr_wr       (cppr_wr),
  .cppr_wdata    (cppr_wdata),
  .acc_valid     (acc_valid),
  .acc_rsp_valid (acc_rsp_valid),
  .acc_rsp_data  (acc_rsp_data),
  .ipb_o         (ipb_o),
  .pipr_o        (pipr_o),
  .irq_o         (irq_o),
  .cppr_q        (cppr_q),
  .nsr_q         (nsr_q)
);

// File: tb/sim_ipp_presenter.sv
module sim_ipp_presenter;
  localparam int NPRIO = 8;
  localparam int PW = 3;
  localparam logic [1:0] OP_SET = 2'd0, OP_WR = 2'd1, OP_ACC = 2'd2;

  // {op, arg, irq, pipr, ipb, rsp}
  localparam int NV = 15;
  localparam logic [42:0] VEC [NV] = '{
    {OP_SET, 8'd3, 1'b0, 8'd0, 8'h10, 16'h0000},
    {OP_WR,  8'd5, 1'b1, 8'd3, 8'h10, 16'h0000},
    {OP_SET, 8'd6, 1'b1, 8'd3, 8'h12, 16'h0000},
    {OP_SET, 8'd1, 1'b1, 8'd1, 8'h52, 16'h0000},
    {OP_WR,  8'd1, 1'b0, 8'd1, 8'h52, 16'h0000},
    {OP_WR,  8'd9, 1'b0, 8'd1, 8'h52, 16'h0000},
    {OP_WR,  8'd7, 1'b1, 8'd1, 8'h52, 16'h0000},
    {OP_ACC, 8'd0, 1'b0, 8'd1, 8'h12, 16'h8007},
    {OP_WR,  8'd4, 1'b1, 8'd3, 8'h12, 16'h0000},
    {OP_ACC, 8'd0, 1'b0, 8'd3, 8'h02, 16'h8004},
    {OP_WR,  8'd7, 1'b1, 8'd6, 8'h02, 16'h0000},
    {OP_ACC, 8'd0, 1'b0, 8'd6, 8'h00, 16'h8007},
    {OP_ACC, 8'd0, 1'b0, 8'd6, 8'h00, 16'h0006},
    {OP_SET, 8'd0, 1'b1, 8'd0, 8'h80, 16'h0000},
    {OP_WR,  8'd0, 1'b0, 8'd0, 8'h80, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic set_valid = 1'b0, cppr_wr = 1'b0, acc_valid = 1'b0;
  logic [PW-1:0] set_prio = '0;
  logic [7:0] cppr_wdata = '0;
  logic acc_rsp_valid, irq_o;
  logic [15:0] acc_rsp_data;
  logic [NPRIO-1:0] ipb_o;
  logic [7:0] pipr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ipp_presenter #(.NPRIO(NPRIO)) u0 (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_prio(set_prio),
    .cppr_wr(cppr_wr), .cppr_wdata(cppr_wdata), .acc_valid(acc_valid),
    .acc_rsp_valid(acc_rsp_valid), .acc_rsp_data(acc_rsp_data),
    .ipb_o(ipb_o), .pipr_o(pipr_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge, sample at next negedge
  task automatic step(input logic s, input logic [7:0] sp, input logic w,
                      input logic [7:0] wd, input logic a);
    set_valid = s; set_prio = sp[PW-1:0]; cppr_wr = w; cppr_wdata = wd; acc_valid = a;
    @(negedge clk);
    set_valid = 1'b0; cppr_wr = 1'b0; acc_valid = 1'b0;
  endtask

  task automatic state(input string req, input logic irq, input logic [7:0] pipr,
                       input logic [7:0] ipb);
    chk(req, 16'(irq_o), 16'(irq));
    chk(req, 16'(pipr_o), 16'(pipr));
    chk(req, 16'(ipb_o), 16'(ipb));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    state("R1", 1'b0, 8'd0, 8'h00);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] arg;
      op  = VEC[i][42:41];
      arg = VEC[i][40:33];
      step(op == OP_SET, arg, op == OP_WR, arg, op == OP_ACC);
      state($sformatf("R2/R3/R4/R5/R7/R10 row %0d", i), VEC[i][32], VEC[i][31:24], VEC[i][23:16]);
      if (op == OP_ACC) begin
        chk("R6 valid", 16'(acc_rsp_valid), 16'd1);
        chk("R6/R8 data", acc_rsp_data, VEC[i][15:0]);
      end else begin
        chk("R6 idle", 16'(acc_rsp_valid), 16'd0);
      end
    end

    // R1: accept right after reset returns zero
    do_reset();
    step(1'b0, 8'd0, 1'b0, 8'd0, 1'b1);
    chk("R1 rsp", acc_rsp_data, 16'h0000);
    state("R1", 1'b0, 8'd0, 8'h00);

    // R9: same-cycle set and threshold write
    step(1'b1, 8'd2, 1'b1, 8'd4, 1'b0);
    state("R9", 1'b1, 8'd2, 8'h20);

    // R11: accept with legal write, write wins
    step(1'b0, 8'd0, 1'b1, 8'd5, 1'b1);
    chk("R11 rsp", acc_rsp_data, 16'h8004);
    state("R11", 1'b0, 8'd5, 8'h00);

    // R3: clamp with less privileged pending
    step(1'b1, 8'd7, 1'b0, 8'd0, 1'b0);
    state("R3 clamp", 1'b0, 8'd5, 8'h01);

    // R5: max value accepted, raw equal to threshold not below
    step(1'b0, 8'd0, 1'b1, 8'd7, 1'b0);
    state("R5 max", 1'b0, 8'd7, 8'h01);
    step(1'b1, 8'd4, 1'b0, 8'd0, 1'b0);
    state("R4", 1'b1, 8'd4, 8'h09);
    step(1'b0, 8'd0, 1'b1, 8'hFF, 1'b0);
    state("R5 reject", 1'b1, 8'd4, 8'h09);
    step(1'b0, 8'd0, 1'b1, 8'd8, 1'b0);
    state("R5 reject 8", 1'b1, 8'd4, 8'h09);

    // R7: accept shows threshold kept at 7
    step(1'b0, 8'd0, 1'b0, 8'd0, 1'b1);
    chk("R7 rsp", acc_rsp_data, 16'h8007);
    state("R7", 1'b0, 8'd4, 8'h01);
    step(1'b0, 8'd0, 1'b0, 8'd0, 1'b1);
    chk("R7 cppr", acc_rsp_data, 16'h0004);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule